// File: doc/BRIEF.md
# Branch Delay-Slot and Nullification Controller

This block controls the front of a deep in-order pipeline with eight stages: fetch start, fetch finish, decode/register read, execute, two data-access stages, tag check and write-back. Branch conditions resolve in execute, three stages after fetch. When execute reports a resolved branch, the instruction directly behind it is the delay slot, which sits in decode. The two younger instructions in the fetch stages are on the sequential path.

A taken branch lets the delay slot run. It clears the two younger instructions and asks fetch to redirect to the target in the same cycle. An ordinary branch that is not taken loses nothing. A "likely" branch that is not taken cancels its delay slot and keeps the sequential instructions.

The block keeps one valid bit per stage. A cleared bit means the instruction in that stage writes no register and no memory. A downstream stall freezes every valid bit and holds back resolution. The kills are applied in the cycle the pipeline advances.

Top module: `brslot_ctrl`

## Requirements
- R1: After reset, every bit of `stage_vld` is 0, and `redirect` and `kill` are 0.
- R2: Bit i of `stage_vld` is stage i. The order is 0 fetch start, 1 fetch finish, 2 decode, 3 execute, 4 and 5 data access, 6 tag check, 7 write-back. On a clock edge with `adv` high, bit 0 takes `fetch_vld`, each other bit takes the bit below it unless that bit is killed, and bit 7 leaves the pipeline.
- R3: When an ordinary branch resolves taken (`br_vld`=1, `br_taken`=1, `br_likely`=0, execute valid, `adv`=1), `redirect` is 1 in that cycle. `kill` is 3'b011, where bit 0 is fetch start, bit 1 is fetch finish and bit 2 is decode. The delay slot in decode reaches execute valid.
- R4: A likely branch that resolves taken behaves exactly as in R3.
- R5: An ordinary branch that resolves not taken gives `redirect`=0 and `kill`=3'b000. Every instruction moves on.
- R6: A likely branch that resolves not taken gives `kill`=3'b100 and `redirect`=0. The decode instruction (the delay slot) does not reach execute valid.
- R7: While `adv` is 0, `redirect` and `kill` stay 0 whatever the branch inputs are. `stage_vld` holds its value, and `fetch_vld` is ignored.
- R8: The branch inputs are ignored while bit 3 (execute) of `stage_vld` is 0. This covers a branch that was itself nullified.
- R9: An instruction that has been nullified stays invalid in every later stage until it leaves the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adv | input | 1 | Pipeline advances this cycle; 0 means stall |
| fetch_vld | input | 1 | A valid instruction enters fetch start on the advance |
| br_vld | input | 1 | Execute holds a branch with its condition resolved |
| br_taken | input | 1 | The resolved branch is taken |
| br_likely | input | 1 | The resolved branch is of the likely kind |
| redirect | output | 1 | Fetch switches to the branch target |
| kill | output | 3 | Per-stage nullify: bit 0 fetch start, bit 1 fetch finish, bit 2 decode |
| stage_vld | output | 8 | Per-stage valid bits, bit 0 fetch start to bit 7 write-back |

## Verification
The core decision is tried with every combination of taken and likely, with a stall, and with execute empty. Each case starts from the same filled pipeline. This separates the redirect kill of the two fetch slots from the delay-slot cancel of the likely not-taken case. It also separates both from the no-effect cases. A nullified branch is then carried into execute to show that its resolution is ignored. A drain with fetch off shows that valid bits move intact down to write-back.

// File: rtl/brslot_ctrl.sv
module brslot_ctrl #(
  parameter int NSTG = 8,
  parameter int EXP  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            fetch_vld,
  input  logic            br_vld,
  input  logic            br_taken,
  input  logic            br_likely,
  output logic            redirect,
  output logic [EXP-1:0]  kill,
  output logic [NSTG-1:0] stage_vld
);

  localparam int DSP = EXP - 1;

  logic [NSTG-1:0] vld_q;
  logic            resolve;
  logic            go_taken;
  logic            drop_slot;

  assign resolve   = adv & br_vld & vld_q[EXP];
  assign go_taken  = resolve & br_taken;
  assign drop_slot = resolve & ~br_taken & br_likely;
  assign redirect  = go_taken;

  genvar g;
  generate
    for (g = 0; g < EXP; g++) begin : g_kill
      if (g == DSP) begin : g_ds
        assign kill[g] = drop_slot;
      end else begin : g_wp
        assign kill[g] = go_taken;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (adv) begin
      vld_q[0] <= fetch_vld;
      for (int i = 1; i < NSTG; i++) begin
        if (i <= EXP) vld_q[i] <= vld_q[i-1] & ~kill[i-1];
        else          vld_q[i] <= vld_q[i-1];
      end
    end
  end

  assign stage_vld = vld_q;

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(stage_vld));
  assert_stall_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |-> (kill == '0 && !redirect));
  assert_taken_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && br_vld && br_taken && stage_vld[EXP]) |=> (!stage_vld[1] && !stage_vld[2]));
  assert_taken_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && br_vld && br_taken && stage_vld[EXP]) |=> (stage_vld[EXP] == $past(stage_vld[DSP])));
  assert_likely_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && br_vld && !br_taken && br_likely && stage_vld[EXP]) |=> !stage_vld[EXP]);
  assert_plain_nt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && br_vld && !br_taken && !br_likely) |=> (stage_vld[EXP:1] == $past(stage_vld[EXP-1:0])));
  assert_empty_ex_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_vld[EXP] |-> (kill == '0 && !redirect));
  assert_dead_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !stage_vld[EXP]) |=> !stage_vld[EXP+1]);

endmodule

// File: tb/brslot_ctrl_tb.sv
module brslot_ctrl_tb;
  localparam int CLK_PER = 10;

  logic clk = 0, rst_n = 0;
  logic adv = 0, fetch_vld = 0, br_vld = 0, br_taken = 0, br_likely = 0;
  logic       redirect;
  logic [2:0] kill;
  logic [7:0] stage_vld;
  int total = 0, bad = 0;

  brslot_ctrl u_dut (.clk(clk), .rst_n(rst_n), .adv(adv), .fetch_vld(fetch_vld),
    .br_vld(br_vld), .br_taken(br_taken), .br_likely(br_likely),
    .redirect(redirect), .kill(kill), .stage_vld(stage_vld));

  always #(CLK_PER/2) clk = ~clk;

  // row: {adv, br_vld, taken, likely, exp_redirect, exp_kill[2:0], exp_next_vld[7:0]}
  localparam logic [15:0] TBL [7] = '{
    {4'b1110, 1'b1, 3'b011, 8'h19},  // R3
    {4'b1111, 1'b1, 3'b011, 8'h19},  // R4
    {4'b1100, 1'b0, 3'b000, 8'h1F},  // R5
    {4'b1101, 1'b0, 3'b100, 8'h17},  // R6
    {4'b0110, 1'b0, 3'b000, 8'h0F},  // R7
    {4'b0101, 1'b0, 3'b000, 8'h0F},  // R7
    {4'b1011, 1'b0, 3'b000, 8'h1F}   // R8 (br_vld low)
  };
  localparam string TAG [7] = '{"R3", "R4", "R5", "R6", "R7", "R7", "R8"};

  task automatic check(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic f, input logic bv, input logic bt, input logic bl);
    adv = a; fetch_vld = f; br_vld = bv; br_taken = bt; br_likely = bl;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic fill();
    rst_n = 0; adv = 0; fetch_vld = 0; br_vld = 0; br_taken = 0; br_likely = 0;
    @(negedge clk); rst_n = 1; @(negedge clk);
    for (int k = 0; k < 4; k++) step(1, 1, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PER * 5000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check(stage_vld == 0 && !redirect && kill == 0, "R1", {redirect, kill, stage_vld}, 12'h0);
    rst_n = 1; @(negedge clk);

    fill();
    check(stage_vld == 8'h0F, "R2", {4'h0, stage_vld}, 12'h00F);

    for (int r = 0; r < 7; r++) begin
      fill();
      adv = TBL[r][15]; fetch_vld = 1; br_vld = TBL[r][14];
      br_taken = TBL[r][13]; br_likely = TBL[r][12];
      #1;
      check({redirect, kill} == TBL[r][11:8], TAG[r], {8'h0, redirect, kill}, {8'h0, TBL[r][11:8]});
      @(posedge clk); @(negedge clk);
      check(stage_vld == TBL[r][7:0], TAG[r], {4'h0, stage_vld}, {4'h0, TBL[r][7:0]});
    end

    // R8/R9: a nullified branch reaches execute and is ignored
    fill();
    step(1, 1, 1, 1, 0);
    check(stage_vld == 8'h19, "R3", {4'h0, stage_vld}, 12'h019);
    step(1, 1, 0, 0, 0);
    check(stage_vld == 8'h33, "R9", {4'h0, stage_vld}, 12'h033);
    adv = 1; br_vld = 1; br_taken = 1; br_likely = 1; #1;
    check(!redirect && kill == 0, "R8", {8'h0, redirect, kill}, 12'h0);
    @(posedge clk); @(negedge clk);
    check(stage_vld == 8'h67, "R8", {4'h0, stage_vld}, 12'h067);
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    check(stage_vld == 8'h9C, "R9", {4'h0, stage_vld}, 12'h09C);

    // R2: drain to write-back with fetch off
    fill();
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0);
    check(stage_vld == 8'hF0, "R2", {4'h0, stage_vld}, 12'h0F0);
    step(1, 0, 0, 0, 0);
    check(stage_vld == 8'hE0, "R2", {4'h0, stage_vld}, 12'h0E0);

    // R7: stall ignores fetch_vld over several cycles
    step(0, 1, 1, 1, 0);
    step(0, 1, 0, 0, 1);
    check(stage_vld == 8'hE0, "R7", {4'h0, stage_vld}, 12'h0E0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule